// File: doc/BRIEF.md
# Serial Flash SPI/QPI Instruction Front End

This block is the slave-side instruction receiver of a serial flash-style device. It watches a serial bus framed by an active-low chip select and captures the first byte of every transaction as an instruction. It then hands the instruction to downstream logic as an 8-bit code with a one-cycle valid strobe. The serial clock, chip select, hardware reset pin and IO lines are all brought into the system clock domain before use. The bus clock is taken as a slow signal that the system clock samples several times per period.

The block keeps a bus-width mode that lasts across transactions. In single-line mode an instruction arrives one bit per serial clock on IO0. In quad mode it arrives one nibble per serial clock on IO0..IO3. Dedicated opcodes switch the mode when a clean transaction ends. A power-on reset, a hardware reset pin or a two-command software reset returns the block to single-line mode.

The block also drives the output enables of the four IO lines. The enables follow a read-drive request from downstream logic and are released whenever no read is being driven.

Top module: `qpi_cmd_frontend`

## Requirements
- R1: After reset, qpiMode is 0, opValid is 0 and ioOe is 4'b0000.
- R2: In single-line mode, each rising serial clock edge with csN low shifts ioIn[0] into the instruction, most significant bit first. After the eighth bit, opValid pulses high for exactly one clock with opCode holding the byte. The idle level of the serial clock (mode 0 or mode 3) has no effect.
- R3: In quad mode, an instruction takes two rising serial clock edges. The first nibble forms opCode[7:4] and the second forms opCode[3:0], with ioIn[3] as the most significant bit of each nibble. opValid pulses once after the second nibble.
- R4: Opcode 8'h35, received in single-line mode, sets qpiMode to 1. The change happens only after csN rises, never while the transaction is still open.
- R5: Opcode 8'hF5, received in a clean transaction, sets qpiMode to 0.
- R6: csN going high aborts a partial instruction. No opValid is produced for it, and the next transaction starts capture from its first bit.
- R7: A mode-change or reset opcode acts only if csN rises exactly at the end of the instruction byte. Any further rising serial clock edge in the same transaction cancels its effect.
- R8: A clean 8'h66 transaction followed directly by a clean 8'h99 transaction sets qpiMode to 0. Any other captured instruction between them cancels the sequence.
- R9: A low level on hwResetN sets qpiMode to 0.
- R10: ioOe is 4'b0000 whenever csN is high or rdDrive is low. With csN low and rdDrive high, ioOe is 4'b0010 in single-line mode and 4'b1111 in quad mode.
- R11: Only the first byte of a transaction is reported. Later serial clock edges in the same transaction produce no opValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| hwResetN | input | 1 | Hardware reset pin, active low, synchronised internally |
| sck | input | 1 | Serial bus clock |
| csN | input | 1 | Chip select, active low |
| ioIn | input | 4 | Input levels of IO0..IO3 |
| rdDrive | input | 1 | Downstream request to drive read data |
| ioOe | output | 4 | Output enables for IO0..IO3 |
| qpiMode | output | 1 | 1 in quad mode, 0 in single-line mode |
| opValid | output | 1 | One-cycle strobe for a captured instruction |
| opCode | output | 8 | Captured instruction byte |

## Verification
A wrong bit counter or shift direction shows up as a wrong opCode value, or as an opValid pulse that is missing or extra. Either shows within three system clocks of the serial clock edge that should have completed the byte. A wrong mode or software-reset arming state does not show until the next transaction. It appears as a wrong qpiMode level a few clocks after csN rises, or as a different ioOe pattern once a read drive is requested. For this reason each mode transition is followed by a capture or an enable check in the opposite width.

// File: rtl/qcf_pkg.sv
package qcf_pkg;
  localparam logic [7:0] OP_QUAD_ON  = 8'h35;
  localparam logic [7:0] OP_QUAD_OFF = 8'hF5;
  localparam logic [7:0] OP_RST_ARM  = 8'h66;
  localparam logic [7:0] OP_RST_GO   = 8'h99;

  typedef struct packed {
    logic shiftEn;   // accept one bus beat into the shifter
    logic byteDone;  // this beat completes the instruction
    logic commit;    // clean frame end with a captured instruction
    logic hwClr;     // synchronised hardware reset
  } ctrlStrobes_t;
endpackage

// File: rtl/qcf_ctrl.sv
module qcf_ctrl
  import qcf_pkg::*;
#(
  parameter int OpBits     = 8,
  parameter int IoLines    = 4,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwResetN,
  input  logic               sck,
  input  logic               csN,
  input  logic [IoLines-1:0] ioIn,
  input  logic               qpi,
  output logic [IoLines-1:0] ioSample,
  output ctrlStrobes_t       strobes
);
  localparam int CntW = $clog2(OpBits) + 1;

  logic [SyncStages:0]  sckPipe, csPipe;
  logic [SyncStages-1:0] hwPipe;
  logic [IoLines-1:0]   ioPipe [SyncStages];
  logic [CntW-1:0]      bitCnt;
  logic                 gotOp, extraBeat;

  logic sckCur, sckPrev, csCur, csPrev, sckRise, frameEnd;
  logic [CntW-1:0] step, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      hwPipe  <= '1;
    end else begin
      sckPipe <= {sckPipe[SyncStages-1:0], sck};
      csPipe  <= {csPipe[SyncStages-1:0], csN};
      hwPipe  <= {hwPipe[SyncStages-2:0], hwResetN};
    end
  end

  for (genvar s = 0; s < SyncStages; s++) begin : g_ioSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ioPipe[s] <= '0;
      else if (s == 0) ioPipe[s] <= ioIn;
      else ioPipe[s] <= ioPipe[(s == 0) ? 0 : s-1];
    end
  end

  assign sckCur   = sckPipe[SyncStages-1];
  assign sckPrev  = sckPipe[SyncStages];
  assign csCur    = csPipe[SyncStages-1];
  assign csPrev   = csPipe[SyncStages];
  assign ioSample = ioPipe[SyncStages-1];
  assign sckRise  = sckCur & ~sckPrev & ~csCur;
  assign frameEnd = csCur & ~csPrev;
  assign step     = qpi ? CntW'(IoLines) : CntW'(1);
  assign cntNext  = bitCnt + step;

  always_comb begin
    strobes          = '0;
    strobes.hwClr    = ~hwPipe[SyncStages-1];
    strobes.shiftEn  = sckRise & ~gotOp & ~strobes.hwClr;
    strobes.byteDone = strobes.shiftEn & (cntNext == CntW'(OpBits));
    strobes.commit   = frameEnd & gotOp & ~extraBeat & ~strobes.hwClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      gotOp     <= 1'b0;
      extraBeat <= 1'b0;
    end else if (strobes.hwClr || csCur) begin
      bitCnt    <= '0;
      gotOp     <= 1'b0;
      extraBeat <= 1'b0;
    end else if (sckRise) begin
      if (gotOp) extraBeat <= 1'b1;
      else if (cntNext == CntW'(OpBits)) begin
        bitCnt <= '0;
        gotOp  <= 1'b1;
      end else bitCnt <= cntNext;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CntW'(OpBits));
  p_frame_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (bitCnt == '0) && !gotOp);
  p_one_byte_per_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteDone |=> !strobes.shiftEn);
endmodule

// File: rtl/qcf_datapath.sv
module qcf_datapath
  import qcf_pkg::*;
#(
  parameter int OpBits  = 8,
  parameter int IoLines = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IoLines-1:0] ioSample,
  input  ctrlStrobes_t       strobes,
  output logic               qpi,
  output logic               opValid,
  output logic [OpBits-1:0]  opCode
);
  logic [OpBits-1:0] shiftReg, shiftNext;
  logic              rstArmed;

  assign shiftNext = qpi ? {shiftReg[OpBits-IoLines-1:0], ioSample}
                         : {shiftReg[OpBits-2:0], ioSample[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      opCode   <= '0;
      opValid  <= 1'b0;
    end else begin
      opValid <= strobes.byteDone;
      if (strobes.shiftEn) shiftReg <= shiftNext;
      if (strobes.byteDone) opCode <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qpi      <= 1'b0;
      rstArmed <= 1'b0;
    end else if (strobes.hwClr) begin
      qpi      <= 1'b0;
      rstArmed <= 1'b0;
    end else if (strobes.commit) begin
      rstArmed <= (opCode == OP_RST_ARM);
      if (opCode == OP_QUAD_ON && !qpi) qpi <= 1'b1;
      if (opCode == OP_QUAD_OFF) qpi <= 1'b0;
      if (opCode == OP_RST_GO && rstArmed) qpi <= 1'b0;
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);
  p_mode_at_frame_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(qpi) |-> $past(strobes.commit || strobes.hwClr));
  p_hw_reset_spi_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hwClr |=> !qpi);
endmodule

// File: rtl/qpi_cmd_frontend.sv
module qpi_cmd_frontend
  import qcf_pkg::*;
#(
  parameter int OpBits     = 8,
  parameter int IoLines    = 4,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hwResetN,
  input  logic               sck,
  input  logic               csN,
  input  logic [IoLines-1:0] ioIn,
  input  logic               rdDrive,
  output logic [IoLines-1:0] ioOe,
  output logic               qpiMode,
  output logic               opValid,
  output logic [OpBits-1:0]  opCode
);
  localparam logic [IoLines-1:0] SpiOe  = IoLines'(2);
  localparam logic [IoLines-1:0] QuadOe = '1;

  ctrlStrobes_t       strobes;
  logic [IoLines-1:0] ioSample;

  qcf_ctrl #(.OpBits(OpBits), .IoLines(IoLines), .SyncStages(SyncStages)) uCtrl (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .sck(sck), .csN(csN),
    .ioIn(ioIn), .qpi(qpiMode), .ioSample(ioSample), .strobes(strobes)
  );

  qcf_datapath #(.OpBits(OpBits), .IoLines(IoLines)) uData (
    .clk(clk), .rstN(rstN), .ioSample(ioSample), .strobes(strobes),
    .qpi(qpiMode), .opValid(opValid), .opCode(opCode)
  );

  assign ioOe = (!csN && rdDrive) ? (qpiMode ? QuadOe : SpiOe) : '0;

  p_oe_shape_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == '0) || (ioOe == SpiOe) || (ioOe == QuadOe));
  p_oe_width_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == QuadOe) |-> qpiMode);
endmodule

// File: tb/tb_qpi_cmd_frontend.sv
`timescale 1ns/1ps
module tb_qpi_cmd_frontend;
  logic clk = 1'b0, rstN = 1'b0, hwResetN = 1'b1, sck = 1'b0, csN = 1'b1;
  logic rdDrive = 1'b0;
  logic [3:0] ioIn = 4'h0;
  logic [3:0] ioOe;
  logic qpiMode, opValid;
  logic [7:0] opCode;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] lastOp = 8'h00;
  bit done = 0;

  always #2 clk = ~clk;

  qpi_cmd_frontend dut (
    .clk(clk), .rstN(rstN), .hwResetN(hwResetN), .sck(sck), .csN(csN),
    .ioIn(ioIn), .rdDrive(rdDrive), .ioOe(ioOe), .qpiMode(qpiMode),
    .opValid(opValid), .opCode(opCode)
  );

  always @(posedge clk) if (opValid) begin
    pulses <= pulses + 1;
    lastOp <= opCode;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic frameOpen(input bit idleHigh);
    sck = idleHigh; #40 csN = 1'b0; #40;
  endtask

  task automatic frameClose();
    #40 csN = 1'b1; sck = 1'b0; #80;
  endtask

  task automatic spiBits(input logic [7:0] b, input int n, input bit idleHigh);
    for (int i = 7; i > 7 - n; i--) begin
      if (idleHigh) begin sck = 1'b0; ioIn[0] = b[i]; #20 sck = 1'b1; #20; end
      else begin ioIn[0] = b[i]; #20 sck = 1'b1; #20 sck = 1'b0; end
    end
  endtask

  task automatic qpiByte(input logic [7:0] b);
    ioIn = b[7:4]; #20 sck = 1'b1; #20 sck = 1'b0;
    ioIn = b[3:0]; #20 sck = 1'b1; #20 sck = 1'b0;
  endtask

  task automatic spiCmd(input logic [7:0] b);
    frameOpen(0); spiBits(b, 8, 0); frameClose();
  endtask

  task automatic qpiCmd(input logic [7:0] b);
    frameOpen(0); qpiByte(b); frameClose();
  endtask

  task automatic tReset();
    check(qpiMode == 0, "R1 qpiMode", qpiMode, 0);
    check(opValid == 0 && pulses == 0, "R1 opValid", pulses, 0);
    check(ioOe == 4'h0, "R1 ioOe", ioOe, 0);
  endtask

  task automatic tSpiCapture();
    int p0 = pulses;
    spiCmd(8'hA5);
    check(pulses == p0 + 1, "R2 pulse count", pulses - p0, 1);
    check(lastOp == 8'hA5, "R2 opcode mode0", lastOp, 8'hA5);
    frameOpen(1); spiBits(8'h3C, 8, 1); frameClose();
    check(lastOp == 8'h3C, "R2 opcode mode3", lastOp, 8'h3C);
    check(pulses == p0 + 2, "R2 pulse count mode3", pulses - p0, 2);
  endtask

  task automatic tPartial();
    int p0 = pulses;
    frameOpen(0); spiBits(8'hFF, 5, 0); frameClose();
    check(pulses == p0, "R6 no pulse on abort", pulses - p0, 0);
    spiCmd(8'h5A);
    check(lastOp == 8'h5A, "R6 restart capture", lastOp, 8'h5A);
  endtask

  task automatic tExtraBeats();
    int p0 = pulses;
    frameOpen(0); spiBits(8'h35, 8, 0); spiBits(8'h00, 8, 0); frameClose();
    check(pulses == p0 + 1, "R11 single report", pulses - p0, 1);
    check(lastOp == 8'h35, "R11 first byte kept", lastOp, 8'h35);
    check(qpiMode == 0, "R7 unclean 35h ignored", qpiMode, 0);
  endtask

  task automatic tSpiOe();
    rdDrive = 1'b1; #1;
    check(ioOe == 4'h0, "R10 released csN high", ioOe, 0);
    csN = 1'b0; #20;
    check(ioOe == 4'b0010, "R10 spi enable", ioOe, 2);
    rdDrive = 1'b0; #1;
    check(ioOe == 4'h0, "R10 released rdDrive low", ioOe, 0);
    #20 csN = 1'b1; #80;
  endtask

  task automatic tEnter();
    frameOpen(0); spiBits(8'h35, 8, 0); #40;
    check(qpiMode == 0, "R4 no change while open", qpiMode, 0);
    frameClose();
    check(qpiMode == 1, "R4 enter quad", qpiMode, 1);
  endtask

  task automatic tQuadCapture();
    int p0 = pulses;
    qpiCmd(8'hC3);
    check(lastOp == 8'hC3, "R3 nibble order", lastOp, 8'hC3);
    check(pulses == p0 + 1, "R3 one pulse", pulses - p0, 1);
    rdDrive = 1'b1; csN = 1'b0; #20;
    check(ioOe == 4'hF, "R10 quad enable", ioOe, 4'hF);
    csN = 1'b1; #1;
    check(ioOe == 4'h0, "R10 quad released", ioOe, 0);
    rdDrive = 1'b0; #80;
  endtask

  task automatic tExit();
    frameOpen(0); qpiByte(8'hF5); qpiByte(8'h00); frameClose();
    check(qpiMode == 1, "R7 unclean F5h ignored", qpiMode, 1);
    qpiCmd(8'hF5);
    check(qpiMode == 0, "R5 exit quad", qpiMode, 0);
    spiCmd(8'h96);
    check(lastOp == 8'h96, "R5 spi capture after exit", lastOp, 8'h96);
  endtask

  task automatic tSoftReset();
    spiCmd(8'h35);
    qpiCmd(8'h66); qpiCmd(8'h05); qpiCmd(8'h99);
    check(qpiMode == 1, "R8 interrupted sequence", qpiMode, 1);
    qpiCmd(8'h66); qpiCmd(8'h99);
    check(qpiMode == 0, "R8 software reset", qpiMode, 0);
  endtask

  task automatic tHwReset();
    spiCmd(8'h35);
    check(qpiMode == 1, "R9 precondition quad", qpiMode, 1);
    hwResetN = 1'b0; #40 hwResetN = 1'b1; #40;
    check(qpiMode == 0, "R9 hardware reset", qpiMode, 0);
  endtask

  initial begin
    #1;
    #20 rstN = 1'b1; #40;
    tReset();
    tSpiCapture();
    tPartial();
    tExtraBeats();
    tSpiOe();
    tEnter();
    tQuadCapture();
    tExit();
    tSoftReset();
    tHwReset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule